// File: doc/BRIEF.md
# Buffered UART Transmitter with Break Generation

This block is the transmit half of a UART. Characters written by the host land in a four-entry queue. A shifter takes them one at a time and sends each as a frame: one low start bit, eight data bits with the least significant bit first, and one high stop bit. Bit boundaries follow a baud tick pulse that comes from outside the block. A frame starts only on a tick, and each bit lasts exactly one tick period. When a character finishes and another one is waiting, the next frame follows with no gap.

The host picks one of three interrupt timings with a 2-bit mode input. The fourth code is reserved and raises no interrupt. An inversion input flips the polarity of the line, both in idle and while a frame is sent. A one-cycle break request arms a special frame: a start bit, twelve zero bits, then a stop bit. That frame goes out at the next frame boundary, and the pending flag clears itself when the frame completes.

Dropping the enable does three things at once. It abandons the frame in flight, empties the queue and returns the line to its idle level. While the enable is low, writes and break requests have no effect.

Top module: `brk_uart_tx`

## Requirements
- R1: A character frame starts at the first baud tick after the character is queued, provided the shifter is free. The frame is a start bit of 0, then the 8 data bits with the least significant bit first, then a stop bit of 1. Each bit holds for exactly one tick period, and a waiting character starts at the tick that ends the previous stop bit.
- R2: The queue holds 4 characters. `buf_full` is 1 only when 4 characters are queued. A write while the queue is full is dropped, and the dropped character is never sent.
- R3: `all_idle` is 1 only when the shifter is not sending and the queue is empty.
- R4: With `irq_mode` = 2'b00, every move of a character from the queue into the shifter raises one interrupt.
- R5: With `irq_mode` = 2'b10, a move raises an interrupt only when it leaves the queue empty.
- R6: With `irq_mode` = 2'b01, one interrupt is raised when a frame's stop bit ends and no character and no break is waiting.
- R7: With `irq_mode` = 2'b11 (reserved), no interrupt is raised.
- R8: `irq` is high for exactly one clock per qualifying event, and it rises in the clock after the tick that caused the event.
- R9: A `brk_set` pulse sets `brk_pending`. At the next frame boundary, a break frame is sent: the line stays low for 13 bit periods (the start bit plus 12 zeros) and then sends one high stop bit. `brk_pending` clears when that frame ends.
- R10: With `tx_inv` = 0 the line idles at 1. With `tx_inv` = 1 the line idles at 0 and every bit of every frame is sent inverted.
- R11: Setting `tx_en` = 0 returns `tx_out` to the idle level in the same cycle. On the next clock the queue is emptied, the frame in flight is abandoned and `brk_pending` is cleared. While `tx_en` = 0, writes and `brk_set` are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; low aborts and flushes |
| wr_en | input | 1 | Write strobe that queues `wr_data` |
| wr_data | input | 8 | Character to queue |
| irq_mode | input | 2 | Interrupt timing: 00 on every move, 10 on a move that empties the queue, 01 when all work is done, 11 none |
| tx_inv | input | 1 | Output polarity inversion |
| brk_set | input | 1 | One-cycle request for a break frame |
| baud_tick | input | 1 | One-cycle bit-rate pulse |
| tx_out | output | 1 | Serial line |
| buf_full | output | 1 | Queue holds 4 characters |
| all_idle | output | 1 | Shifter and queue both empty |
| brk_pending | output | 1 | Break armed or being sent |
| irq | output | 1 | Single-cycle interrupt pulse |

## Verification
The bench sends all 256 byte values, then repeats a few of them with the line inverted. A design that sent the most significant bit first, stretched or shortened a bit, or lost a character while frames run back to back would decode to the wrong byte. It writes five characters inside one tick period: a queue that accepted the fifth character, or never raised full, would deliver five bytes instead of four. It counts interrupts for three queued characters under each mode code. A design that mixed up the modes, fired under the reserved code or held the pulse for more than one clock would give the wrong count. It measures how long the line stays low during a break, aborts a frame mid-flight and writes while disabled. A wrong break length, a flag that stays set after the break, or a flush that left data behind would be caught.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
   typedef enum logic [1:0] {
      IRQ_ON_MOVE  = 2'b00,
      IRQ_ON_DONE  = 2'b01,
      IRQ_ON_EMPTY = 2'b10,
      IRQ_NONE     = 2'b11
   } txirq_mode_e;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   flush,
   input  logic                   push,
   input  logic [W-1:0]           din,
   input  logic                   pop,
   output logic [W-1:0]           dout,
   output logic [$clog2(DEPTH):0] count,
   output logic                   full,
   output logic                   empty,
   output logic                   accepted
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("txq_fifo: DEPTH must be a power of two of at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("txq_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] cnt;
   logic          pop_ok;

   assign full     = (cnt == CW'(DEPTH));
   assign empty    = (cnt == '0);
   assign accepted = push && !full && !flush;
   assign pop_ok   = pop && !empty && !flush;
   assign count    = cnt;
   assign dout     = mem[rd_ptr];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (accepted && wr_ptr == AW'(g)) mem[g] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (accepted) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)   rd_ptr <= rd_ptr + 1'b1;
         case ({accepted, pop_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> $stable(cnt));
endmodule

// File: rtl/txq_shift.sv
module txq_shift #(
   parameter int DATA_W    = 8,
   parameter int BRK_ZEROS = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              tick,
   input  logic              have_char,
   input  logic [DATA_W-1:0] char_in,
   input  logic              brk_pend,
   output logic              load_char,
   output logic              load_brk,
   output logic              done,
   output logic              busy,
   output logic              brk_active,
   output logic              line_raw
);
   localparam int SH_W     = BRK_ZEROS + 1;
   localparam int CHAR_LEN = DATA_W + 2;
   localparam int BRK_LEN  = BRK_ZEROS + 2;
   localparam int CNT_W    = $clog2(BRK_LEN);
   localparam int PAD_W    = SH_W - DATA_W - 1;

   if (BRK_ZEROS <= DATA_W) begin : g_bad_brk
      $error("txq_shift: BRK_ZEROS must exceed DATA_W");
   end

   logic [SH_W-1:0]  sh;
   logic [CNT_W-1:0] cnt, last_cnt;
   logic             busy_q, brk_q;
   logic             at_end, free, start_ok, brk_want;

   assign last_cnt   = brk_q ? CNT_W'(BRK_LEN - 1) : CNT_W'(CHAR_LEN - 1);
   assign at_end     = busy_q && tick && (cnt == last_cnt);
   assign free       = !busy_q || at_end;
   assign start_ok   = enable && tick && free;
   assign brk_want   = brk_pend && !(at_end && brk_q);
   assign load_brk   = start_ok && brk_want;
   assign load_char  = start_ok && !brk_want && have_char;
   assign done       = enable && at_end;
   assign busy       = busy_q;
   assign brk_active = brk_q;
   assign line_raw   = busy_q ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh     <= '1;
         cnt    <= '0;
         busy_q <= 1'b0;
         brk_q  <= 1'b0;
      end else if (!enable) begin
         sh     <= '1;
         cnt    <= '0;
         busy_q <= 1'b0;
         brk_q  <= 1'b0;
      end else if (load_brk) begin
         sh     <= '0;
         cnt    <= '0;
         busy_q <= 1'b1;
         brk_q  <= 1'b1;
      end else if (load_char) begin
         sh     <= {{PAD_W{1'b1}}, char_in, 1'b0};
         cnt    <= '0;
         busy_q <= 1'b1;
         brk_q  <= 1'b0;
      end else if (at_end) begin
         sh     <= '1;
         cnt    <= '0;
         busy_q <= 1'b0;
         brk_q  <= 1'b0;
      end else if (busy_q && tick) begin
         sh     <= {1'b1, sh[SH_W-1:1]};
         cnt    <= cnt + 1'b1;
      end
   end

   a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> (line_raw == 1'b0));
   a_r1_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !brk_q && cnt == CNT_W'(CHAR_LEN - 1)) |-> line_raw);
   a_r9_brk_low: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && brk_q && cnt <= CNT_W'(BRK_ZEROS)) |-> !line_raw);
   a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !busy_q);
endmodule

// File: rtl/txq_irq.sv
module txq_irq
   import uart_brk_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        enable,
   input  txirq_mode_e mode,
   input  logic        load_char,
   input  logic        drained,
   input  logic        done,
   input  logic        nothing_left,
   output logic        irq
);
   logic fire;

   always_comb begin
      unique case (mode)
         IRQ_ON_MOVE:  fire = load_char;
         IRQ_ON_EMPTY: fire = load_char && drained;
         IRQ_ON_DONE:  fire = done && nothing_left;
         default:      fire = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= enable && fire;
   end

   a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   a_r7_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(mode) != IRQ_NONE));
endmodule

// File: rtl/brk_uart_tx.sv
module brk_uart_tx
   import uart_brk_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 4,
   parameter int BRK_ZEROS = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        irq_mode,
   input  logic              tx_inv,
   input  logic              brk_set,
   input  logic              baud_tick,
   output logic              tx_out,
   output logic              buf_full,
   output logic              all_idle,
   output logic              brk_pending,
   output logic              irq
);
   localparam int CW = $clog2(DEPTH) + 1;

   logic [DATA_W-1:0] head;
   logic [CW-1:0]     q_count;
   logic              q_full, q_empty, q_accepted;
   logic              load_char, load_brk, done, busy, brk_active, line_raw;
   logic              drained, nothing_left, brk_q;

   txq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (!tx_en),
      .push     (wr_en && tx_en),
      .din      (wr_data),
      .pop      (load_char),
      .dout     (head),
      .count    (q_count),
      .full     (q_full),
      .empty    (q_empty),
      .accepted (q_accepted)
   );

   txq_shift #(.DATA_W(DATA_W), .BRK_ZEROS(BRK_ZEROS)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (tx_en),
      .tick       (baud_tick),
      .have_char  (!q_empty),
      .char_in    (head),
      .brk_pend   (brk_q),
      .load_char  (load_char),
      .load_brk   (load_brk),
      .done       (done),
      .busy       (busy),
      .brk_active (brk_active),
      .line_raw   (line_raw)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   brk_q <= 1'b0;
      else if (!tx_en)              brk_q <= 1'b0;
      else if (brk_set)             brk_q <= 1'b1;
      else if (done && brk_active)  brk_q <= 1'b0;
   end

   assign drained      = (q_count == CW'(1)) && !q_accepted;
   assign nothing_left = !load_char && !load_brk && q_empty && !q_accepted
                         && !(brk_q && !brk_active) && !brk_set;

   txq_irq u_irq (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (tx_en),
      .mode         (txirq_mode_e'(irq_mode)),
      .load_char    (load_char),
      .drained      (drained),
      .done         (done),
      .nothing_left (nothing_left),
      .irq          (irq)
   );

   assign tx_out      = (tx_en ? line_raw : 1'b1) ^ tx_inv;
   assign buf_full    = q_full;
   assign all_idle    = !busy && q_empty;
   assign brk_pending = brk_q;

   a_r3_idle_not_full: assert property (@(posedge clk) disable iff (!rst_n)
      all_idle |-> !buf_full);
   a_r9_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(brk_q) && $past(tx_en)) |-> $past(brk_active));
   a_r11_no_pend_off: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> !brk_q);
endmodule

// File: tb/brk_uart_tx_tb.sv
module brk_uart_tx_tb;
   localparam int TP = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_en = 1'b0, wr_en = 1'b0, tx_inv = 1'b0, brk_set = 1'b0, baud_tick = 1'b0;
   logic [7:0] wr_data = '0;
   logic [1:0] irq_mode = 2'b00;
   logic       tx_out, buf_full, all_idle, brk_pending, irq;

   int checks = 0, fails = 0;
   bit finished = 0;

   int phase = 0;
   int rs = 0, rn = 0;
   logic [7:0] rbyte;
   logic [7:0] rx_q [0:1023];
   int rx_cnt = 0;
   int zrun = 0, last_zrun = 0;
   int irq_cnt = 0, irq_dbl = 0;
   logic irq_prev = 1'b0;

   always #2.5 clk = ~clk;

   brk_uart_tx u_dut (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_en(wr_en), .wr_data(wr_data),
      .irq_mode(irq_mode), .tx_inv(tx_inv), .brk_set(brk_set), .baud_tick(baud_tick),
      .tx_out(tx_out), .buf_full(buf_full), .all_idle(all_idle),
      .brk_pending(brk_pending), .irq(irq)
   );

   // tick generation, mid-bit line receiver and interrupt counting
   always @(negedge clk) begin
      logic lvl;
      if (phase == TP / 2) begin
         lvl = tx_out ^ tx_inv;
         if (!lvl) zrun++;
         else begin
            if (zrun > 0) last_zrun = zrun;
            zrun = 0;
         end
         case (rs)
            0: if (!lvl) begin rs = 1; rn = 0; end
            1: begin
               rbyte[rn] = lvl;
               rn++;
               if (rn == 8) rs = 2;
            end
            default: begin
               if (lvl) begin rx_q[rx_cnt] = rbyte; rx_cnt++; end
               rs = 0;
            end
         endcase
      end
      if (irq) irq_cnt++;
      if (irq && irq_prev) irq_dbl++;
      irq_prev = irq;
      phase = (phase + 1) % TP;
      baud_tick = (phase == 0);
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk);
      while (buf_full) @(negedge clk);
      wr_en = 1'b1; wr_data = b;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic settle(input int ticks);
      @(negedge clk);
      while (!all_idle || brk_pending) @(negedge clk);
      repeat (ticks * TP) @(negedge clk);
   endtask

   task automatic burst(input int n, input logic [7:0] first);
      @(posedge clk iff baud_tick);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_data = first + 8'(i);
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic irq_case(input logic [1:0] m, input int exp, input string tag);
      int base_irq, base_rx;
      settle(2);
      irq_mode = m;
      base_irq = irq_cnt;
      base_rx = rx_cnt;
      burst(3, 8'h21);
      settle(2);
      check(irq_cnt - base_irq == exp, tag, irq_cnt - base_irq, exp);
      check(rx_cnt - base_rx == 3, {tag, " bytes"}, rx_cnt - base_rx, 3);
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      int base;
      repeat (4) @(negedge clk);
      // R3 R10 R8: reset state
      check(tx_out == 1'b1, "R10 reset idle high", tx_out, 1);
      check(all_idle == 1'b1, "R3 reset idle", all_idle, 1);
      check(buf_full == 1'b0, "R2 reset not full", buf_full, 0);
      check(irq == 1'b0 && brk_pending == 1'b0, "R8 reset irq/brk", irq, 0);
      rst_n = 1'b1;
      tx_en = 1'b1;
      repeat (3 * TP) @(negedge clk);

      // R1 R4: exhaustive byte sweep, mode 00
      base = rx_cnt;
      begin
         int b_irq;
         b_irq = irq_cnt;
         for (int b = 0; b < 256; b++) put(8'(b));
         settle(2);
         check(rx_cnt - base == 256, "R1 sweep count", rx_cnt - base, 256);
         for (int b = 0; b < 256; b++)
            check(rx_q[base + b] == 8'(b), "R1 sweep byte", int'(rx_q[base + b]), b);
         check(irq_cnt - b_irq == 256, "R4 sweep irq count", irq_cnt - b_irq, 256);
      end

      // R2: five writes inside one tick period, fifth dropped
      base = rx_cnt;
      burst(5, 8'h90);
      check(buf_full == 1'b1, "R2 full after 4", buf_full, 1);
      check(all_idle == 1'b0, "R3 busy not idle", all_idle, 0);
      settle(2);
      check(rx_cnt - base == 4, "R2 fifth dropped", rx_cnt - base, 4);
      for (int i = 0; i < 4; i++)
         check(rx_q[base + i] == 8'h90 + 8'(i), "R2 order", int'(rx_q[base + i]), 8'h90 + i);
      check(all_idle == 1'b1 && buf_full == 1'b0, "R3 idle after drain", all_idle, 1);

      // R4 R5 R6 R7: interrupt modes
      irq_case(2'b00, 3, "R4 mode00");
      irq_case(2'b10, 1, "R5 mode10");
      irq_case(2'b01, 1, "R6 mode01");
      irq_case(2'b11, 0, "R7 mode11");
      check(irq_dbl == 0, "R8 single-cycle pulse", irq_dbl, 0);
      irq_mode = 2'b00;

      // R9: break frame
      settle(1);
      @(negedge clk); brk_set = 1'b1;
      @(negedge clk); brk_set = 1'b0;
      check(brk_pending == 1'b1, "R9 pending set", brk_pending, 1);
      last_zrun = 0;
      while (brk_pending) @(negedge clk);
      check(last_zrun == 13, "R9 low run length", last_zrun, 13);
      check(tx_out == 1'b1, "R9 line idle after", tx_out, 1);
      repeat (14 * TP) @(negedge clk);
      base = rx_cnt;
      put(8'h3C);
      settle(2);
      check(rx_q[base] == 8'h3C, "R9 byte after break", int'(rx_q[base]), 8'h3C);

      // R10: inverted line
      settle(1);
      @(negedge clk); tx_inv = 1'b1;
      @(negedge clk);
      check(tx_out == 1'b0, "R10 inverted idle", tx_out, 0);
      repeat (2 * TP) @(negedge clk);
      base = rx_cnt;
      put(8'h00); put(8'hFF); put(8'h5A); put(8'hA5);
      settle(2);
      check(rx_q[base] == 8'h00, "R10 inv 00", int'(rx_q[base]), 8'h00);
      check(rx_q[base + 1] == 8'hFF, "R10 inv FF", int'(rx_q[base + 1]), 8'hFF);
      check(rx_q[base + 2] == 8'h5A, "R10 inv 5A", int'(rx_q[base + 2]), 8'h5A);
      check(rx_q[base + 3] == 8'hA5, "R10 inv A5", int'(rx_q[base + 3]), 8'hA5);
      @(negedge clk); tx_inv = 1'b0;
      repeat (2 * TP) @(negedge clk);

      // R11: abort and flush
      put(8'h33); put(8'h44); put(8'h55);
      repeat (4 * TP) @(negedge clk);
      check(all_idle == 1'b0, "R11 busy before abort", all_idle, 0);
      tx_en = 1'b0;
      #0;
      check(tx_out == 1'b1, "R11 line idle same cycle", tx_out, 1);
      @(negedge clk);
      check(all_idle == 1'b1 && buf_full == 1'b0, "R11 flushed", all_idle, 1);
      wr_en = 1'b1; wr_data = 8'h77; brk_set = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; brk_set = 1'b0;
      @(negedge clk);
      check(brk_pending == 1'b0, "R11 break ignored off", brk_pending, 0);
      check(all_idle == 1'b1, "R11 write ignored off", all_idle, 1);
      repeat (14 * TP) @(negedge clk);
      base = rx_cnt;
      tx_en = 1'b1;
      repeat (15 * TP) @(negedge clk);
      check(rx_cnt == base, "R11 nothing left to send", rx_cnt - base, 0);
      put(8'h66);
      settle(2);
      check(rx_cnt - base == 1 && rx_q[base] == 8'h66, "R11 fresh byte",
            int'(rx_q[base]), 8'h66);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule